// File: doc/BRIEF.md
# Serial Panel Register Writer

This block is a three-wire serial master that programs 8-bit registers inside a display panel. Each write moves one 16-bit frame over an enable line, a clock line and a data line. The frame carries the register address in its upper byte and the value in its lower byte, and the most significant bit goes out first. The serial clock is derived from the system clock by a counter, and the `HALF_CYCLES` parameter sets the length of each serial half-period in system cycles.

Three kinds of request exist. A single write sends one caller-supplied address/value pair. A panel-on request plays a built-in five-command wake-up script. A panel-off request sends one built-in shutdown command. While any of these is in progress, `busy` is held high and every new request is dropped. When the whole operation is finished, `done` pulses once.

Top module: `panel_reg_writer`

## Requirements
- R1: While no operation is in progress (and after reset), `ser_en` and `ser_clk` are high and `ser_dat` is low; `busy` and `done` are low after reset.
- R2: Each frame is exactly 16 bits. Bits 15..8 are the register address and bits 7..0 are the value. Bits are sent MSB first and are captured on each rising edge of `ser_clk` while `ser_en` is low.
- R3: `ser_dat` changes only while `ser_clk` is low. It is stable across every high phase of `ser_clk` inside a frame.
- R4: Every low phase of `ser_clk` lasts `HALF_CYCLES` system cycles. `ser_en` stays low for exactly 33*`HALF_CYCLES` cycles per frame: one half-period of setup, then 16 full bit periods.
- R5: Between two consecutive frames, `ser_en` stays high for at least `HALF_CYCLES` system cycles.
- R6: A panel-on request sends these frames in this order: 0x051E, 0x055E, 0x078D, 0x1301, 0x055F.
- R7: A panel-off request sends the single frame 0x055E.
- R8: `busy` is high in the cycle after a request is accepted and stays high until `done`. Any request made while `busy` is high is ignored and produces no frame.
- R9: `done` is high for exactly one cycle per accepted request. It fires after the last frame of that request, not once per frame.
- R10: When requests arrive in the same cycle, a single write wins over panel-on, and panel-on wins over panel-off.
- R11: `ser_clk` never leaves its high level while `ser_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Request a single register write |
| wr_addr | input | 8 | Register address for a single write |
| wr_data | input | 8 | Value for a single write |
| on_req | input | 1 | Request the panel wake-up script |
| off_req | input | 1 | Request the panel shutdown command |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| ser_en | output | 1 | Serial enable, active low |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data, idles low |

## Verification
The assertions assume that requests are single-cycle strobes sampled on the system clock. They also assume that reset is applied before any request. They make no assumption about the request values themselves, because a request made while `busy` is high must have no effect. The stimulus drives every request on the falling system edge for exactly one cycle. It deliberately fires requests into a running operation, and it fires several requests together, to exercise the drop and priority rules.

// File: rtl/spw_pkg.sv
package spw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPEN,
        PH_LOW,
        PH_HIGH,
        PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SINGLE,
        SQ_ON,
        SQ_OFF
    } seq_e;

    localparam int WAKE_LEN = 5;
    localparam int WAKE_IW  = $clog2(WAKE_LEN);

    localparam logic [15:0] SLEEP_CMD = 16'h055E;

    function automatic logic [15:0] wake_cmd(input logic [WAKE_IW-1:0] idx);
        logic [15:0] c;
        case (idx)
            WAKE_IW'(0): c = 16'h051E;
            WAKE_IW'(1): c = 16'h055E;
            WAKE_IW'(2): c = 16'h078D;
            WAKE_IW'(3): c = 16'h1301;
            default:     c = 16'h055F;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spw_shifter.sv
module spw_shifter
    import spw_pkg::*;
#(
    parameter int HALF_CYCLES = 4,
    parameter int FRAME_BITS  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  idle,
    output logic                  fin,
    output logic                  ser_en,
    output logic                  ser_clk,
    output logic                  ser_dat
);

    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYCLES - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

    typedef struct packed {
        phase_e                ph;
        logic [CW-1:0]         cnt;
        logic [BW-1:0]         bitn;
        logic [FRAME_BITS-1:0] sh;
        logic                  en;
        logic                  sclk;
        logic                  sdat;
        logic                  fin;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   slot_end;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        slot_end = (st_q.cnt == CNT_LAST);
        if (st_q.ph != PH_IDLE) begin
            st_d.cnt = slot_end ? '0 : st_q.cnt + 1'b1;
        end
        case (st_q.ph)
            PH_IDLE: begin
                if (go) begin
                    st_d.ph   = PH_OPEN;
                    st_d.en   = 1'b0;
                    st_d.sh   = frame;
                    st_d.cnt  = '0;
                    st_d.bitn = '0;
                end
            end
            PH_OPEN: begin
                if (slot_end) begin
                    st_d.ph   = PH_LOW;
                    st_d.sclk = 1'b0;
                    st_d.sdat = st_q.sh[FRAME_BITS-1];
                end
            end
            PH_LOW: begin
                if (slot_end) begin
                    st_d.ph   = PH_HIGH;
                    st_d.sclk = 1'b1;
                end
            end
            PH_HIGH: begin
                if (slot_end) begin
                    if (st_q.bitn == BIT_LAST) begin
                        st_d.ph   = PH_GAP;
                        st_d.en   = 1'b1;
                        st_d.sdat = 1'b0;
                        st_d.bitn = '0;
                    end else begin
                        st_d.ph   = PH_LOW;
                        st_d.sclk = 1'b0;
                        st_d.bitn = st_q.bitn + 1'b1;
                        st_d.sh   = st_q.sh << 1;
                        st_d.sdat = st_q.sh[FRAME_BITS-2];
                    end
                end
            end
            PH_GAP: begin
                if (slot_end) begin
                    st_d.ph  = PH_IDLE;
                    st_d.fin = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.en   <= 1'b1;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle    = (st_q.ph == PH_IDLE);
    assign fin     = st_q.fin;
    assign ser_en  = st_q.en;
    assign ser_clk = st_q.sclk;
    assign ser_dat = st_q.sdat;

endmodule

// File: rtl/spw_sequencer.sv
module spw_sequencer
    import spw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_start,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        on_req,
    input  logic        off_req,
    input  logic        sh_idle,
    input  logic        sh_fin,
    output logic        go,
    output logic [15:0] frame,
    output logic        busy,
    output logic        done
);

    localparam logic [WAKE_IW-1:0] WAKE_LAST = WAKE_IW'(WAKE_LEN - 1);

    typedef struct packed {
        seq_e               mode;
        logic [WAKE_IW-1:0] idx;
        logic               pend;
        logic [15:0]        user;
        logic               done;
    } sq_st_t;

    sq_st_t st_d, st_q;

    always_comb begin
        case (st_q.mode)
            SQ_SINGLE: frame = st_q.user;
            SQ_ON:     frame = wake_cmd(st_q.idx);
            default:   frame = SLEEP_CMD;
        endcase
    end

    assign go = (st_q.mode != SQ_IDLE) && st_q.pend && sh_idle;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.mode == SQ_IDLE) begin
            st_d.idx  = '0;
            st_d.pend = 1'b1;
            if (wr_start) begin
                st_d.mode = SQ_SINGLE;
                st_d.user = {wr_addr, wr_data};
            end else if (on_req) begin
                st_d.mode = SQ_ON;
            end else if (off_req) begin
                st_d.mode = SQ_OFF;
            end
        end else begin
            if (go) begin
                st_d.pend = 1'b0;
            end
            if (sh_fin) begin
                if (st_q.mode == SQ_ON && st_q.idx != WAKE_LAST) begin
                    st_d.idx  = st_q.idx + 1'b1;
                    st_d.pend = 1'b1;
                end else begin
                    st_d.mode = SQ_IDLE;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= SQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.mode != SQ_IDLE);
    assign done = st_q.done;

endmodule

// File: rtl/panel_reg_writer.sv
module panel_reg_writer #(
    parameter int HALF_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_start,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       on_req,
    input  logic       off_req,
    output logic       busy,
    output logic       done,
    output logic       ser_en,
    output logic       ser_clk,
    output logic       ser_dat
);

    logic        go;
    logic [15:0] frame;
    logic        sh_idle;
    logic        sh_fin;

    spw_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .on_req   (on_req),
        .off_req  (off_req),
        .sh_idle  (sh_idle),
        .sh_fin   (sh_fin),
        .go       (go),
        .frame    (frame),
        .busy     (busy),
        .done     (done)
    );

    spw_shifter #(
        .HALF_CYCLES (HALF_CYCLES),
        .FRAME_BITS  (16)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .frame   (frame),
        .idle    (sh_idle),
        .fin     (sh_fin),
        .ser_en  (ser_en),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat)
    );

endmodule

// File: rtl/panel_reg_writer_chk.sv
module panel_reg_writer_chk #(
    parameter int HALF_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ser_en,
    input logic ser_clk,
    input logic ser_dat
);

    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!ser_clk) begin
            low_run <= (low_run == 16'hFFFF) ? low_run : low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_en && ser_clk && !ser_dat));

    p_dat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk) && !ser_en && !$past(ser_en)) |-> $stable(ser_dat));

    p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> (low_run == 16'(HALF_CYCLES)));

    p_open_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_en) |-> ser_clk);

    p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_clk_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> ser_clk);

endmodule

bind panel_reg_writer panel_reg_writer_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .ser_en  (ser_en),
    .ser_clk (ser_clk),
    .ser_dat (ser_dat)
);

// File: tb/test_panel_reg_writer.sv
module test_panel_reg_writer;

    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       on_req = 1'b0;
    logic       off_req = 1'b0;
    logic       busy, done, ser_en, ser_clk, ser_dat;

    always #2 clk = ~clk;

    panel_reg_writer #(.HALF_CYCLES(H)) i_panel_reg_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .on_req   (on_req),
        .off_req  (off_req),
        .busy     (busy),
        .done     (done),
        .ser_en   (ser_en),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] fr_val [0:63];
    int          fr_bits[0:63];
    int          fr_len [0:63];
    int          nfr = 0;
    int          done_cnt = 0;
    int          low_min = 1000000, low_max = 0;
    int          gap_min = 1000000;
    int          hold_err = 0;
    int          gated_err = 0;

    logic        p_en = 1'b1, p_clk = 1'b1, p_dat = 1'b0;
    logic [15:0] cur;
    int          cur_bits = 0, cur_len = 0, low_run = 0, hi_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (ser_en && !ser_clk) gated_err++;
            if (!ser_clk) low_run++;
            if (ser_clk && !p_clk) begin
                if (low_run < low_min) low_min = low_run;
                if (low_run > low_max) low_max = low_run;
                low_run = 0;
                if (!ser_en) begin
                    cur = {cur[14:0], ser_dat};
                    cur_bits++;
                end
            end
            if (ser_clk && p_clk && !ser_en && !p_en && ser_dat != p_dat) hold_err++;
            if (!ser_en && p_en) begin
                if (nfr > 0 && hi_run < gap_min) gap_min = hi_run;
                cur = '0;
                cur_bits = 0;
                cur_len = 0;
            end
            if (!ser_en) cur_len++;
            if (ser_en) hi_run++; else hi_run = 0;
            if (ser_en && !p_en && nfr < 64) begin
                fr_val[nfr] = cur;
                fr_bits[nfr] = cur_bits;
                fr_len[nfr] = cur_len;
                nfr++;
            end
            p_en = ser_en;
            p_clk = ser_clk;
            p_dat = ser_dat;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done(input int base);
        int n = 0;
        while (done_cnt <= base && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic check_frame(input int k, input logic [15:0] exp, input string req);
        chk(fr_val[k] == exp, req, "frame value", int'(fr_val[k]), int'(exp));
        chk(fr_bits[k] == 16, "R2", "bit count", fr_bits[k], 16);
        chk(fr_len[k] == 33 * H, "R4", "enable low length", fr_len[k], 33 * H);
    endtask

    task automatic single(input logic [7:0] a, input logic [7:0] d);
        int nb = nfr;
        int db = done_cnt;
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
        wait_done(db);
        chk(nfr == nb + 1, "R2", "frame count", nfr - nb, 1);
        check_frame(nb, {a, d}, "R2");
        chk(done_cnt == db + 1, "R9", "done pulses", done_cnt - db, 1);
        chk(ser_en && ser_clk && !ser_dat, "R1", "idle levels", {ser_en, ser_clk, ser_dat}, 3'b110);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nb, db;
        logic [15:0] wake [0:4];
        wake[0] = 16'h051E; wake[1] = 16'h055E; wake[2] = 16'h078D;
        wake[3] = 16'h1301; wake[4] = 16'h055F;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ser_en == 1'b1, "R1", "reset ser_en", int'(ser_en), 1);
        chk(ser_clk == 1'b1, "R1", "reset ser_clk", int'(ser_clk), 1);
        chk(ser_dat == 1'b0, "R1", "reset ser_dat", int'(ser_dat), 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 sweep: walking ones and arithmetic patterns
        for (int k = 0; k < 8; k++) single(8'(1 << k), 8'(8'h80 >> k));
        for (int i = 0; i < 16; i++) single(8'(i * 37 + 5), 8'(~(i * 37 + 5)) ^ 8'(i << 4));
        single(8'h00, 8'h00);
        single(8'hFF, 8'hFF);

        // R6 / R5 / R9: wake-up script
        nb = nfr; db = done_cnt; gap_min = 1000000;
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
        wait_done(db);
        chk(nfr == nb + 5, "R6", "wake frame count", nfr - nb, 5);
        for (int k = 0; k < 5; k++) check_frame(nb + k, wake[k], "R6");
        chk(done_cnt == db + 1, "R9", "one done per script", done_cnt - db, 1);
        chk(gap_min >= H, "R5", "gap between frames", gap_min, H);

        // R7: shutdown command
        nb = nfr; db = done_cnt;
        @(negedge clk); off_req = 1'b1;
        @(negedge clk); off_req = 1'b0;
        wait_done(db);
        chk(nfr == nb + 1, "R7", "off frame count", nfr - nb, 1);
        check_frame(nb, 16'h055E, "R7");

        // R10: simultaneous requests, single over on over off
        nb = nfr; db = done_cnt;
        @(negedge clk); wr_addr = 8'hA5; wr_data = 8'h3C; wr_start = 1'b1; on_req = 1'b1; off_req = 1'b1;
        @(negedge clk); wr_start = 1'b0; on_req = 1'b0; off_req = 1'b0;
        wait_done(db);
        chk(nfr == nb + 1, "R10", "single wins count", nfr - nb, 1);
        check_frame(nb, 16'hA53C, "R10");
        nb = nfr; db = done_cnt;
        @(negedge clk); on_req = 1'b1; off_req = 1'b1;
        @(negedge clk); on_req = 1'b0; off_req = 1'b0;
        wait_done(db);
        chk(nfr == nb + 5, "R10", "on wins over off", nfr - nb, 5);
        check_frame(nb, 16'h051E, "R10");

        // R8: requests while busy are ignored
        nb = nfr; db = done_cnt;
        @(negedge clk); wr_addr = 8'h12; wr_data = 8'h34; wr_start = 1'b1;
        @(negedge clk); wr_start = 1'b0;
        repeat (20) @(negedge clk);
        wr_addr = 8'hAB; wr_data = 8'hCD; wr_start = 1'b1; on_req = 1'b1; off_req = 1'b1;
        @(negedge clk); wr_start = 1'b0; on_req = 1'b0; off_req = 1'b0;
        wait_done(db);
        repeat (200) @(negedge clk);
        chk(nfr == nb + 1, "R8", "frames after busy request", nfr - nb, 1);
        check_frame(nb, 16'h1234, "R8");
        chk(done_cnt == db + 1, "R9", "done after ignored request", done_cnt - db, 1);
        chk(busy == 1'b0, "R8", "busy after ignore", int'(busy), 0);

        // R3 / R4 / R11: whole-run waveform properties
        chk(hold_err == 0, "R3", "data change while clk high", hold_err, 0);
        chk(low_min == H, "R4", "min clk low", low_min, H);
        chk(low_max == H, "R4", "max clk low", low_max, H);
        chk(gated_err == 0, "R11", "clk low while enable high", gated_err, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule